// File: doc/BRIEF.md
# Packet Framer with Running XOR Check

This block sits behind a half-bit timing classifier on a track-signal decoder. It takes one decided bit at a time, together with a strobe that flags a timing fault, and turns the stream into packets. It searches for a preamble of one bits, then collects bytes most significant bit first. A separator bit follows each byte: a zero means another byte follows and a one ends the packet. While the bytes arrive, the block folds each one into a bytewise XOR accumulator. When the end bit arrives, the verdict is therefore known at once. The block raises either a one-cycle good strobe, together with a one-cycle answer enable for a response that was prepared in advance, or a one-cycle reject strobe with a two-bit cause.

The bit input cannot be stalled, because the line keeps running. The input is therefore a plain valid qualifier with no ready, and the outputs are strobes with no back-pressure. The packet bytes and the byte count are taken straight from the assembly store. They stay unchanged from the verdict until the start bit of the next packet is accepted. That is at least eleven bit times later, so the consumer has that long to read them.

Top module: `pkt_framer`

## Requirements
- R1: After reset, pkt_good, answer_en and pkt_err are low and pkt_len is zero.
- R2: A packet opens only on a zero bit that follows at least PRE_MIN (default 10) consecutive one bits. With nine ones before the zero, nothing is reported.
- R3: Bytes are assembled most significant bit first. Byte i of the packet appears on pkt_bytes[8*i+7:8*i], and pkt_len gives the number of bytes received. Both hold their values after the verdict.
- R4: An end bit (a one in the separator position) that closes 3 to 6 bytes whose XOR, check byte included, is zero raises pkt_good and answer_en for exactly one cycle. This is the cycle after the clock edge that samples the end bit.
- R5: An end bit that closes 3 to 6 bytes with a nonzero XOR raises pkt_err with err_cause 2'b01.
- R6: An end bit after fewer than 3 bytes raises pkt_err with err_cause 2'b10, and pkt_len shows the short count. The length test takes priority over the XOR test.
- R7: A zero separator after the sixth byte aborts the packet at that bit, with pkt_err and err_cause 2'b00.
- R8: A timing_err while a packet is open aborts it with pkt_err and err_cause 2'b11, even if a bit is presented in the same cycle. During preamble search, timing_err reports nothing and clears the preamble count.
- R9: After any verdict the block searches for a fresh full preamble. The end bit does not count toward it.
- R10: pkt_good and pkt_err are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A decided bit is presented this cycle |
| bit_value | input | 1 | Value of the presented bit |
| timing_err | input | 1 | Timing fault from the bit classifier |
| pkt_good | output | 1 | One-cycle strobe for a valid packet |
| answer_en | output | 1 | One-cycle release of the prepared response, only on a good check |
| pkt_err | output | 1 | One-cycle reject strobe |
| err_cause | output | 2 | 00 separator, 01 XOR mismatch, 10 length, 11 timing abort |
| pkt_len | output | 3 | Bytes received in the current or last packet |
| pkt_bytes | output | 48 | Received bytes, byte 0 in the low eight bits |

## Verification
The bench sweeps packet lengths 1 to 8 with preambles of 9, 10 and 13 ones, each with a correct check byte and with a corrupted one. A framer that counted one bit too few or too many in the preamble would accept the nine-one frames or lose the ten-one frames. One that ranked the XOR test above the length test would report short packets as mismatches. One that let the seventh byte through would write past the store or report a length error late. Separate scenarios present a timing fault together with the end bit of an otherwise good packet, and a fault in the middle of a preamble. They also send a nine-one preamble right after a rejected packet, which catches a framer that counts the end bit as a preamble one.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

  typedef enum logic [1:0] {
    CAUSE_SEP    = 2'd0,
    CAUSE_XOR    = 2'd1,
    CAUSE_LEN    = 2'd2,
    CAUSE_TIMING = 2'd3
  } rej_cause_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_SEP  = 2'd2
  } frm_state_e;

endpackage

// File: rtl/pkt_framer_preamble.sv
module pkt_framer_preamble #(
  parameter int PRE_MIN = 10,
  parameter int PRE_W   = $clog2(PRE_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunting,
  input  logic flush,
  input  logic bit_stb,
  input  logic bit_val,
  output logic start_seen
);

  logic [PRE_W-1:0] ones_q;
  logic             enough;

  // Saturating count: reaching the threshold is all that matters.
  assign enough     = (ones_q == PRE_W'(PRE_MIN));
  assign start_seen = hunting & ~flush & bit_stb & ~bit_val & enough;

  always_ff @(posedge clk) begin
    if (!rst_n || !hunting || flush) begin
      ones_q <= '0;
    end else if (bit_stb) begin
      if (!bit_val)    ones_q <= '0;
      else if (!enough) ones_q <= ones_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/pkt_framer_shifter.sv
module pkt_framer_shifter #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              shift_en,
  input  logic              bit_val,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_next
);

  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  assign byte_next = {sh_q[BYTE_W-2:0], bit_val};
  assign byte_done = shift_en && (idx_q == IDX_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (shift_en) begin
      sh_q  <= byte_next;
      idx_q <= byte_done ? '0 : idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/pkt_framer_store.sv
module pkt_framer_store #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 6,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic                        wr_en,
  input  logic [BYTE_W-1:0]           wr_byte,
  output logic [LEN_W-1:0]            count,
  output logic [BYTE_W-1:0]           xor_acc,
  output logic [MAX_BYTES*BYTE_W-1:0] bytes
);

  logic room;
  assign room = (count < LEN_W'(MAX_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      count   <= '0;
      xor_acc <= '0;
    end else if (wr_en && room) begin
      count   <= count + LEN_W'(1);
      xor_acc <= xor_acc ^ wr_byte;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot_q <= '0;
      else if (wr_en && count == LEN_W'(g))        slot_q <= wr_byte;
    end
    assign bytes[g*BYTE_W +: BYTE_W] = slot_q;
  end

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int PRE_MIN   = 10,
  parameter int MIN_BYTES = 3,
  parameter int MAX_BYTES = 6,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_valid,
  input  logic                        bit_value,
  input  logic                        timing_err,
  output logic                        pkt_good,
  output logic                        answer_en,
  output logic                        pkt_err,
  output logic [1:0]                  err_cause,
  output logic [LEN_W-1:0]            pkt_len,
  output logic [MAX_BYTES*BYTE_W-1:0] pkt_bytes
);
  import pkt_framer_pkg::*;

  frm_state_e        state_q;
  rej_cause_e        cause_q;
  logic              good_q, err_q;
  logic              hunting, start_seen, shift_en, byte_done;
  logic [BYTE_W-1:0] byte_next, xor_acc;
  logic [LEN_W-1:0]  count;
  logic              full, short, xor_bad;

  assign hunting  = (state_q == ST_HUNT);
  assign shift_en = (state_q == ST_DATA) && bit_valid && !timing_err;
  assign full     = (count == LEN_W'(MAX_BYTES));
  assign short    = (count <  LEN_W'(MIN_BYTES));
  assign xor_bad  = |xor_acc;

  pkt_framer_preamble #(.PRE_MIN(PRE_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .hunting(hunting), .flush(timing_err),
    .bit_stb(bit_valid), .bit_val(bit_value), .start_seen(start_seen)
  );

  pkt_framer_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .restart(start_seen), .shift_en(shift_en),
    .bit_val(bit_value), .byte_done(byte_done), .byte_next(byte_next)
  );

  pkt_framer_store #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .restart(start_seen), .wr_en(byte_done),
    .wr_byte(byte_next), .count(count), .xor_acc(xor_acc), .bytes(pkt_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cause_q <= CAUSE_SEP;
      good_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      good_q <= 1'b0;
      err_q  <= 1'b0;
      if (timing_err) begin
        if (!hunting) begin
          err_q   <= 1'b1;
          cause_q <= CAUSE_TIMING;
        end
        state_q <= ST_HUNT;
      end else if (bit_valid) begin
        unique case (state_q)
          ST_HUNT: if (start_seen) state_q <= ST_DATA;
          ST_DATA: if (byte_done)  state_q <= ST_SEP;
          ST_SEP: begin
            if (!bit_value) begin
              if (full) begin
                err_q   <= 1'b1;
                cause_q <= CAUSE_SEP;
                state_q <= ST_HUNT;
              end else begin
                state_q <= ST_DATA;
              end
            end else begin
              state_q <= ST_HUNT;
              if (short) begin
                err_q   <= 1'b1;
                cause_q <= CAUSE_LEN;
              end else if (xor_bad) begin
                err_q   <= 1'b1;
                cause_q <= CAUSE_XOR;
              end else begin
                good_q  <= 1'b1;
              end
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign pkt_good  = good_q;
  assign answer_en = good_q;
  assign pkt_err   = err_q;
  assign err_cause = cause_q;
  assign pkt_len   = count;

endmodule

// File: rtl/pkt_framer_checker.sv
module pkt_framer_checker #(
  parameter int MIN_BYTES = 3,
  parameter int MAX_BYTES = 6,
  parameter int LEN_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             bit_value,
  input logic             timing_err,
  input logic             pkt_good,
  input logic             answer_en,
  input logic             pkt_err,
  input logic [1:0]       err_cause,
  input logic [LEN_W-1:0] pkt_len
);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_good |-> !pkt_err);

  a_r10_good_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_good |=> !pkt_good);

  a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |=> !pkt_err);

  a_r4_len_window: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_good |-> (answer_en && pkt_len >= LEN_W'(MIN_BYTES) && pkt_len <= LEN_W'(MAX_BYTES)));

  a_r4_after_end_bit: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_good |-> $past(bit_valid && bit_value && !timing_err));

  a_r8_timing_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err && err_cause == 2'd3) |-> $past(timing_err));

  a_r6_short_len: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err && err_cause == 2'd2) |-> pkt_len < LEN_W'(MIN_BYTES));

  a_r7_sep_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err && err_cause == 2'd0) |-> (pkt_len == LEN_W'(MAX_BYTES) && $past(bit_valid && !bit_value)));

endmodule

bind pkt_framer pkt_framer_checker #(
  .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
  .timing_err(timing_err), .pkt_good(pkt_good), .answer_en(answer_en),
  .pkt_err(pkt_err), .err_cause(err_cause), .pkt_len(pkt_len)
);

// File: tb/pkt_framer_bench.sv
module pkt_framer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_value = 1'b0;
  logic        timing_err = 1'b0;
  logic        pkt_good, answer_en, pkt_err;
  logic [1:0]  err_cause;
  logic [2:0]  pkt_len;
  logic [47:0] pkt_bytes;

  always #10 clk = ~clk;

  pkt_framer u_pkt_framer (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
    .timing_err(timing_err), .pkt_good(pkt_good), .answer_en(answer_en),
    .pkt_err(pkt_err), .err_cause(err_cause), .pkt_len(pkt_len), .pkt_bytes(pkt_bytes)
  );

  int gcnt = 0, acnt = 0, ecnt = 0, both = 0;
  int lcause = -1, llen = -1;
  int tests = 0, fails = 0;
  logic [7:0] pb [0:7];

  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_good) gcnt <= gcnt + 1;
      if (answer_en) acnt <= acnt + 1;
      if (pkt_err) begin
        ecnt   <= ecnt + 1;
        lcause <= int'(err_cause);
        llen   <= int'(pkt_len);
      end
      if (pkt_good && pkt_err) both <= both + 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired: act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic v, input logic te);
    @(negedge clk);
    bit_valid  = 1'b1;
    bit_value  = v;
    timing_err = te;
    @(negedge clk);
    bit_valid  = 1'b0;
    timing_err = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) send_bit(b[k], 1'b0);
  endtask

  task automatic flush();
    @(negedge clk);
    timing_err = 1'b1;
    @(negedge clk);
    timing_err = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input int pre, input int n, input logic corrupt, input logic end_te);
    logic [7:0] x;
    x = 8'h00;
    for (int i = 0; i < n - 1; i++) begin
      pb[i] = 8'((i * 37 + n * 11 + pre * 3 + 5) & 255);
      x ^= pb[i];
    end
    pb[n-1] = x ^ (corrupt ? 8'h01 : 8'h00);
    for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      send_byte(pb[i]);
      if (i < n - 1) send_bit(1'b0, 1'b0);
      else           send_bit(1'b1, end_te);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input int pre, input int n, input logic corrupt);
    int g0, a0, e0, dg, da, de;
    flush();
    g0 = gcnt; a0 = acnt; e0 = ecnt;
    send_frame(pre, n, corrupt, 1'b0);
    dg = gcnt - g0; da = acnt - a0; de = ecnt - e0;
    if (pre < 10) begin
      chk(dg == 0 && de == 0, "R2 short preamble", dg + de, 0);
    end else if (n > 6) begin
      chk(de == 1 && dg == 0, "R7 reject count", de, 1);
      chk(lcause == 0, "R7 cause", lcause, 0);
      chk(llen == 6, "R7 length", llen, 6);
    end else if (n < 3) begin
      chk(de == 1 && dg == 0, "R6 reject count", de, 1);
      chk(lcause == 2, "R6 cause", lcause, 2);
      chk(llen == n, "R6 length", llen, n);
    end else if (corrupt) begin
      chk(de == 1 && dg == 0 && da == 0, "R5 reject count", de, 1);
      chk(lcause == 1, "R5 cause", lcause, 1);
    end else begin
      chk(dg == 1 && de == 0, "R4 good count", dg, 1);
      chk(da == 1, "R4 answer count", da, 1);
      chk(int'(pkt_len) == n, "R3 length", int'(pkt_len), n);
      for (int i = 0; i < n; i++)
        chk(pkt_bytes[i*8 +: 8] == pb[i], "R3 byte", int'(pkt_bytes[i*8 +: 8]), int'(pb[i]));
    end
  endtask

  initial begin
    int g0, e0;
    repeat (3) @(negedge clk);
    chk(pkt_good == 0 && answer_en == 0 && pkt_err == 0, "R1 strobes", int'(pkt_good | pkt_err), 0);
    chk(pkt_len == 0, "R1 length", int'(pkt_len), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int p = 0; p < 3; p++)
      for (int n = 1; n <= 8; n++)
        for (int c = 0; c < 2; c++)
          run_case(p == 0 ? 9 : (p == 1 ? 10 : 13), n, c[0]);

    // R8: timing fault on the end bit of a packet that would be good
    flush();
    g0 = gcnt; e0 = ecnt;
    send_frame(10, 4, 1'b0, 1'b1);
    chk(gcnt == g0, "R8 no good on fault", gcnt - g0, 0);
    chk(ecnt - e0 == 1 && lcause == 3, "R8 timing cause", lcause, 3);

    // R8: fault in the middle of a byte
    flush();
    e0 = ecnt;
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_byte(8'hA5);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    @(negedge clk); timing_err = 1'b1; @(negedge clk); timing_err = 1'b0;
    repeat (2) @(negedge clk);
    chk(ecnt - e0 == 1 && lcause == 3, "R8 mid byte abort", lcause, 3);

    // R8: fault during preamble search clears the ones count
    flush();
    g0 = gcnt; e0 = ecnt;
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
    @(negedge clk); timing_err = 1'b1; @(negedge clk); timing_err = 1'b0;
    chk(ecnt == e0, "R8 silent in hunt", ecnt - e0, 0);
    send_frame(5, 3, 1'b0, 1'b0);
    chk(gcnt == g0 && ecnt == e0, "R8 count cleared", (gcnt - g0) + (ecnt - e0), 0);

    // R9: end bit of a rejected packet does not count toward the next preamble
    flush();
    g0 = gcnt; e0 = ecnt;
    send_frame(10, 3, 1'b1, 1'b0);
    send_frame(9, 3, 1'b0, 1'b0);
    chk(ecnt - e0 == 1 && gcnt == g0, "R9 fresh preamble needed", gcnt - g0, 0);
    send_frame(10, 5, 1'b0, 1'b0);
    chk(gcnt - g0 == 1, "R9 full preamble accepted", gcnt - g0, 1);

    chk(both == 0, "R10 exclusive strobes", both, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule